// File: doc/BRIEF.md
# Prefixed bit/rotate instruction executor

This block carries out the second byte of a bit-manipulation instruction from an 8-bit processor core. That byte comes after the prefix byte. The core hands over the byte on `start`, together with the current flag byte, the HL address and the hidden address latch, called memptr here. The block then takes these steps:

- It splits the byte into a group, a sub-operation or bit index, and an operand selector.
- It fetches the operand, either from the core's register file or from memory at HL.
- It applies a rotate or shift, a bit test, a bit clear or a bit set.
- It writes the result back and produces the new flag byte.

When the instruction is finished, the block raises `done` for one cycle. The same cycle presents the flag byte and the instruction's nominal T-state cost, so the core can advance its cycle accounting.

The control is a single state machine with these states:

| State | Job | Next state |
|---|---|---|
| `ST_IDLE` | Waits for `start`. | `ST_RREG` for a register operand, `ST_MRD` when the selector is 6 |
| `ST_RREG` | Captures the register read data. | `ST_EXEC` |
| `ST_MRD` | Holds a memory read until `mem_ack`. | `ST_EXEC` on ack |
| `ST_EXEC` | Registers the result, flags and cost. | `ST_MWR` for a memory operand outside the test group, otherwise `ST_DONE` |
| `ST_MWR` | Holds the memory write until `mem_ack`. | `ST_DONE` on ack |
| `ST_DONE` | Pulses `done` and performs any register write-back. | `ST_IDLE` |

Top module: `cbx_exec`

## Requirements
- R1: The opcode splits into group g = bits 7:6, index y = bits 5:3 and selector s = bits 2:0. The selector picks the operand as follows:
  - s = 0 to 5 and s = 7 address register-file entry s, where 0=B, 1=C, 2=D, 3=E, 4=H, 5=L and 7=A.
  - s = 6 reads memory at HL.
  - A register result is written back to the same index s.
- R2: Group 0 performs a rotate or shift chosen by y, as below. RL and RR shift in the incoming carry flag. SRA keeps bit 7. SLL forces bit 0 to 1.

  | y | Operation |
  |---|---|
  | 0 | RLC |
  | 1 | RRC |
  | 2 | RL |
  | 3 | RR |
  | 4 | SLA |
  | 5 | SRA |
  | 6 | SLL |
  | 7 | SRL |
- R3: The flag byte uses these bit positions: S=7, Z=6, Y=5, H=4, X=3, P/V=2, N=1, C=0. A group-0 result sets the flags as follows:
  - C takes the bit shifted out.
  - H and N are 0.
  - S, Y and X are copied from result bits 7, 5 and 3.
  - Z is set when the result is zero.
  - P/V is 1 when the result has an even number of ones.
- R4: Group 1 (BIT y) leaves the operand unchanged and sets the flags as follows:
  - Z and P/V are set to the inverse of operand bit y.
  - H is 1 and N is 0.
  - S is 1 only when y = 7 and the tested bit is 1.
  - C is kept.
  - For a register operand, Y and X are operand bits 5 and 3.
- R5: For group 1 with s = 6, Y and X come from bits 13 and 11 of memptr (its high byte's bits 5 and 3), not from the operand, and memory is read but never written.
- R6: Group 2 clears bit y and group 3 sets bit y of the operand. Both return the incoming flag byte unchanged.
- R7: Groups 0, 2 and 3 write back exactly once. A register operand is written to the register file. A memory operand is written to memory at HL. Group 1 writes nothing.
- R8: `cycles` reports the T-state cost:
  - 8 for a register operand.
  - 15 for a memory operand in groups 0, 2 or 3.
  - 12 for a memory operand in group 1.
- R9: `done` is a single-cycle pulse that carries valid `flags_out` and `cycles`. While reset is held, `done`, `mem_rd`, `mem_wr` and `rf_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing `opcode` (sampled in ST_IDLE) |
| opcode | input | 8 | Second instruction byte |
| flags_in | input | 8 | Flag byte before the instruction |
| hl | input | ADDR_W | Address used for memory operands |
| memptr | input | ADDR_W | Hidden address latch; its high byte feeds Y/X for memory BIT |
| rf_rsel | output | 3 | Register-file read index |
| rf_rdata | input | 8 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write strobe |
| rf_wsel | output | 3 | Register-file write index |
| rf_wdata | output | 8 | Register-file write data |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Memory read request, held until ack |
| mem_wr | output | 1 | Memory write request, held until ack |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory acknowledge |
| done | output | 1 | Instruction complete (one cycle) |
| flags_out | output | 8 | Resulting flag byte |
| cycles | output | CYC_W | T-state cost of the instruction |

## Verification
The bench covers every rotate variant, and it aims at the ones that depend on the incoming carry or that fill bit 0 or bit 7 unusually:
- A design that ignored the carry in RL/RR, or treated SLL as SLA, would return a result off by one bit.
- A design that took Y/X from the operand for a memory BIT would show the operand's bits, not memptr's.

The bench also probes the following cases:
- BIT 7 versus BIT 6 with the tested bit set, where a wrong S term would set S for every index.
- Zero results, where a reversed parity sense would invert P/V.
- The write-back routing, where a memory BIT that writes, or a write to the wrong register index, is counted at the interfaces.
- The three cost classes, each of which must report its own T-state count.

// File: rtl/cbx_pkg.sv
package cbx_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] SEL_MEM = 3'd6;

    localparam int FL_C  = 0;
    localparam int FL_N  = 1;
    localparam int FL_PV = 2;
    localparam int FL_X  = 3;
    localparam int FL_H  = 4;
    localparam int FL_Y  = 5;
    localparam int FL_Z  = 6;
    localparam int FL_S  = 7;

    typedef enum logic [1:0] {
        GRP_ROT = 2'd0,
        GRP_BIT = 2'd1,
        GRP_RES = 2'd2,
        GRP_SET = 2'd3
    } grp_e;

    typedef enum logic [2:0] {
        ROT_RLC = 3'd0,
        ROT_RRC = 3'd1,
        ROT_RL  = 3'd2,
        ROT_RR  = 3'd3,
        ROT_SLA = 3'd4,
        ROT_SRA = 3'd5,
        ROT_SLL = 3'd6,
        ROT_SRL = 3'd7
    } rot_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RREG,
        ST_MRD,
        ST_EXEC,
        ST_MWR,
        ST_DONE
    } st_e;

    typedef struct packed {
        grp_e             grp;
        logic [SEL_W-1:0] sub;
        logic [SEL_W-1:0] sel;
        logic             is_mem;
    } dec_t;

endpackage

// File: rtl/cbx_decode.sv
module cbx_decode
    import cbx_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output dec_t              dec
);
    always_comb begin
        dec.grp    = grp_e'(op[7:6]);
        dec.sub    = op[5:3];
        dec.sel    = op[2:0];
        dec.is_mem = (op[2:0] == SEL_MEM);
    end
endmodule

// File: rtl/cbx_alu.sv
module cbx_alu
    import cbx_pkg::*;
(
    input  grp_e              grp,
    input  logic [SEL_W-1:0]  sub,
    input  logic              is_mem,
    input  logic [BYTE_W-1:0] opnd,
    input  logic [BYTE_W-1:0] fin,
    input  logic [BYTE_W-1:0] mph,
    output logic [BYTE_W-1:0] res,
    output logic [BYTE_W-1:0] flg
);
    logic [BYTE_W-1:0] rot_r;
    logic              rot_c;
    logic [BYTE_W-1:0] mask;
    logic              tbit;

    always_comb begin
        rot_r = opnd;
        rot_c = fin[FL_C];
        unique case (rot_e'(sub))
            ROT_RLC: begin rot_r = {opnd[6:0], opnd[7]};  rot_c = opnd[7]; end
            ROT_RRC: begin rot_r = {opnd[0], opnd[7:1]};  rot_c = opnd[0]; end
            ROT_RL:  begin rot_r = {opnd[6:0], fin[FL_C]}; rot_c = opnd[7]; end
            ROT_RR:  begin rot_r = {fin[FL_C], opnd[7:1]}; rot_c = opnd[0]; end
            ROT_SLA: begin rot_r = {opnd[6:0], 1'b0};     rot_c = opnd[7]; end
            ROT_SRA: begin rot_r = {opnd[7], opnd[7:1]};  rot_c = opnd[0]; end
            ROT_SLL: begin rot_r = {opnd[6:0], 1'b1};     rot_c = opnd[7]; end
            ROT_SRL: begin rot_r = {1'b0, opnd[7:1]};     rot_c = opnd[0]; end
            default: begin rot_r = opnd;                  rot_c = fin[FL_C]; end
        endcase
    end

    assign mask = BYTE_W'(1) << sub;
    assign tbit = |(opnd & mask);

    always_comb begin
        res = opnd;
        flg = fin;
        unique case (grp)
            GRP_ROT: begin
                res        = rot_r;
                flg[FL_S]  = rot_r[7];
                flg[FL_Z]  = (rot_r == '0);
                flg[FL_Y]  = rot_r[5];
                flg[FL_H]  = 1'b0;
                flg[FL_X]  = rot_r[3];
                flg[FL_PV] = ~^rot_r;
                flg[FL_N]  = 1'b0;
                flg[FL_C]  = rot_c;
            end
            GRP_BIT: begin
                res        = opnd;
                flg[FL_S]  = tbit && (sub == 3'd7);
                flg[FL_Z]  = ~tbit;
                flg[FL_PV] = ~tbit;
                flg[FL_H]  = 1'b1;
                flg[FL_N]  = 1'b0;
                flg[FL_Y]  = is_mem ? mph[5] : opnd[5];
                flg[FL_X]  = is_mem ? mph[3] : opnd[3];
            end
            GRP_RES: res = opnd & ~mask;
            GRP_SET: res = opnd | mask;
            default: res = opnd;
        endcase
    end
endmodule

// File: rtl/cbx_cost.sv
module cbx_cost
    import cbx_pkg::*;
#(
    parameter int CYC_W       = 5,
    parameter int BASE_CYC    = 8,
    parameter int MEM_RMW_CYC = 7,
    parameter int MEM_BIT_CYC = 4
) (
    input  grp_e             grp,
    input  logic             is_mem,
    output logic [CYC_W-1:0] cyc
);
    localparam logic [CYC_W-1:0] C_BASE = CYC_W'(BASE_CYC);
    localparam logic [CYC_W-1:0] C_RMW  = CYC_W'(BASE_CYC + MEM_RMW_CYC);
    localparam logic [CYC_W-1:0] C_BIT  = CYC_W'(BASE_CYC + MEM_BIT_CYC);

    always_comb begin
        if (!is_mem)              cyc = C_BASE;
        else if (grp == GRP_BIT)  cyc = C_BIT;
        else                      cyc = C_RMW;
    end
endmodule

// File: rtl/cbx_exec.sv
module cbx_exec
    import cbx_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int CYC_W       = 5,
    parameter int BASE_CYC    = 8,
    parameter int MEM_RMW_CYC = 7,
    parameter int MEM_BIT_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [7:0]        flags_in,
    input  logic [ADDR_W-1:0] hl,
    input  logic [ADDR_W-1:0] memptr,
    output logic [2:0]        rf_rsel,
    input  logic [7:0]        rf_rdata,
    output logic              rf_we,
    output logic [2:0]        rf_wsel,
    output logic [7:0]        rf_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    output logic              done,
    output logic [7:0]        flags_out,
    output logic [CYC_W-1:0]  cycles
);
    localparam int MPH_LSB = ADDR_W - BYTE_W;

    st_e               state, nxt;
    dec_t              dec_in, dec_q;
    logic [BYTE_W-1:0] fin_q, mph_q, opnd_q, res_q, flg_q;
    logic [ADDR_W-1:0] hl_q;
    logic [CYC_W-1:0]  cyc_q;
    logic [BYTE_W-1:0] alu_res, alu_flg;
    logic [CYC_W-1:0]  cost;

    cbx_decode u_dec (
        .op  (opcode),
        .dec (dec_in)
    );

    cbx_alu u_alu (
        .grp    (dec_q.grp),
        .sub    (dec_q.sub),
        .is_mem (dec_q.is_mem),
        .opnd   (opnd_q),
        .fin    (fin_q),
        .mph    (mph_q),
        .res    (alu_res),
        .flg    (alu_flg)
    );

    cbx_cost #(
        .CYC_W       (CYC_W),
        .BASE_CYC    (BASE_CYC),
        .MEM_RMW_CYC (MEM_RMW_CYC),
        .MEM_BIT_CYC (MEM_BIT_CYC)
    ) u_cost (
        .grp    (dec_q.grp),
        .is_mem (dec_q.is_mem),
        .cyc    (cost)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = dec_in.is_mem ? ST_MRD : ST_RREG;
            ST_RREG: nxt = ST_EXEC;
            ST_MRD:  if (mem_ack) nxt = ST_EXEC;
            ST_EXEC: nxt = (dec_q.is_mem && dec_q.grp != GRP_BIT) ? ST_MWR : ST_DONE;
            ST_MWR:  if (mem_ack) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // datapath captures
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q  <= '0;
            fin_q  <= '0;
            mph_q  <= '0;
            hl_q   <= '0;
            opnd_q <= '0;
            res_q  <= '0;
            flg_q  <= '0;
            cyc_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    dec_q <= dec_in;
                    fin_q <= flags_in;
                    mph_q <= memptr[ADDR_W-1:MPH_LSB];
                    hl_q  <= hl;
                end
                ST_RREG: opnd_q <= rf_rdata;
                ST_MRD:  if (mem_ack) opnd_q <= mem_rdata;
                ST_EXEC: begin
                    res_q <= alu_res;
                    flg_q <= alu_flg;
                    cyc_q <= cost;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rf_rsel   = dec_q.sel;
        rf_wsel   = dec_q.sel;
        rf_wdata  = res_q;
        mem_addr  = hl_q;
        mem_wdata = res_q;
        mem_rd    = (state == ST_MRD);
        mem_wr    = (state == ST_MWR);
        done      = (state == ST_DONE);
        rf_we     = (state == ST_DONE) && !dec_q.is_mem && (dec_q.grp != GRP_BIT);
        flags_out = flg_q;
        cycles    = cyc_q;
    end

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_bit_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || rf_we) |-> dec_q.grp != GRP_BIT);

    a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && rf_we));

    a_r1_mem_only_sel6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> dec_q.sel == SEL_MEM);

    a_r8_cost_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles == CYC_W'(BASE_CYC) ||
                  cycles == CYC_W'(BASE_CYC + MEM_RMW_CYC) ||
                  cycles == CYC_W'(BASE_CYC + MEM_BIT_CYC)));

    a_r5_mem_bit_xy: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dec_q.grp == GRP_BIT && dec_q.is_mem) |->
            (flags_out[FL_Y] == mph_q[5] && flags_out[FL_X] == mph_q[3]));

    a_r6_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (dec_q.grp == GRP_RES || dec_q.grp == GRP_SET)) |-> flags_out == fin_q);

    a_r4_bit_h: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dec_q.grp == GRP_BIT) |-> (flags_out[FL_H] && !flags_out[FL_N]));

endmodule

// File: tb/cbx_exec_bench.sv
module cbx_exec_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] HL_VAL = 16'h40A5;
    localparam int NV = 16;

    // {opcode, flags_in, operand, memptr_hi, exp_result, exp_flags, exp_cycles}
    localparam logic [55:0] VECS [NV] = '{
        {8'h00, 8'h00, 8'h85, 8'h00, 8'h0B, 8'h09, 8'd8},   // RLC B
        {8'h09, 8'h00, 8'h01, 8'h00, 8'h80, 8'h81, 8'd8},   // RRC C
        {8'h12, 8'h01, 8'h80, 8'h00, 8'h01, 8'h01, 8'd8},   // RL D, carry in
        {8'h1B, 8'h00, 8'h01, 8'h00, 8'h00, 8'h45, 8'd8},   // RR E -> zero
        {8'h24, 8'hFF, 8'h7F, 8'h00, 8'hFE, 8'hA8, 8'd8},   // SLA H
        {8'h2D, 8'h00, 8'h81, 8'h00, 8'hC0, 8'h85, 8'd8},   // SRA L
        {8'h37, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'd8},   // SLL A
        {8'h3E, 8'h00, 8'hF0, 8'h00, 8'h78, 8'h2C, 8'd15},  // SRL (HL)
        {8'h7F, 8'h01, 8'h80, 8'h00, 8'h80, 8'h91, 8'd8},   // BIT 7,A set
        {8'h58, 8'h00, 8'h20, 8'h00, 8'h20, 8'h74, 8'd8},   // BIT 3,B clear
        {8'h46, 8'h00, 8'hFE, 8'h08, 8'hFE, 8'h5C, 8'd12},  // BIT 0,(HL)
        {8'hA1, 8'hC3, 8'hFF, 8'h00, 8'hEF, 8'hC3, 8'd8},   // RES 4,C
        {8'hD6, 8'h10, 8'h00, 8'h00, 8'h04, 8'h10, 8'd15},  // SET 2,(HL)
        {8'hFF, 8'h00, 8'h01, 8'h00, 8'h81, 8'h00, 8'd8},   // SET 7,A
        {8'h86, 8'h55, 8'h01, 8'h00, 8'h00, 8'h55, 8'd15},  // RES 0,(HL)
        {8'h75, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h38, 8'd8}    // BIT 6,L set
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  flags_in = '0;
    logic [15:0] memptr = '0;
    logic [2:0]  rf_rsel, rf_wsel;
    logic [7:0]  rf_rdata, rf_wdata, mem_wdata, mem_rdata, flags_out;
    logic        rf_we, mem_rd, mem_wr, mem_ack, done;
    logic [15:0] mem_addr;
    logic [4:0]  cycles;

    logic [7:0]  regs [8];
    logic [7:0]  mem_byte = 8'h00;

    int          rw_cnt = 0, mw_cnt = 0, mr_cnt = 0;
    logic [2:0]  rw_sel = '0;
    logic [7:0]  rw_val = '0, mw_val = '0;
    logic [15:0] mw_adr = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_rdata  = regs[rf_rsel];
    assign mem_ack   = mem_rd | mem_wr;
    assign mem_rdata = (mem_addr == HL_VAL) ? mem_byte : 8'hEE;

    always @(posedge clk) begin
        if (rf_we) begin
            rw_cnt <= rw_cnt + 1;
            rw_sel <= rf_wsel;
            rw_val <= rf_wdata;
        end
        if (mem_wr) begin
            mw_cnt <= mw_cnt + 1;
            mw_val <= mem_wdata;
            mw_adr <= mem_addr;
        end
        if (mem_rd) mr_cnt <= mr_cnt + 1;
    end

    cbx_exec u_cbx_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opcode    (opcode),
        .flags_in  (flags_in),
        .hl        (HL_VAL),
        .memptr    (memptr),
        .rf_rsel   (rf_rsel),
        .rf_rdata  (rf_rdata),
        .rf_we     (rf_we),
        .rf_wsel   (rf_wsel),
        .rf_wdata  (rf_wdata),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .done      (done),
        .flags_out (flags_out),
        .cycles    (cycles)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input logic [55:0] v, input int idx);
        logic [7:0] op, fin, val, mph, eres, eflg, ecyc;
        logic [2:0] s;
        logic [1:0] g;
        int rw0, mw0, mr0;
        string freq, rreq;
        {op, fin, val, mph, eres, eflg, ecyc} = v;
        s = op[2:0];
        g = op[7:6];
        for (int i = 0; i < 8; i++) regs[i] = 8'h10 + 8'(i);
        mem_byte = 8'h5A;
        if (s == 3'd6) mem_byte = val;
        else           regs[s] = val;
        if (g == 2'd0)      begin freq = "R3"; rreq = "R2"; end
        else if (g == 2'd1) freq = (s == 3'd6) ? "R5" : "R4";
        else                begin freq = "R6"; rreq = "R6"; end
        rw0 = rw_cnt; mw0 = mw_cnt; mr0 = mr_cnt;

        @(negedge clk);
        start = 1'b1; opcode = op; flags_in = fin; memptr = {mph, 8'h3C};
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 40 && !done; k++) @(negedge clk);
        check("R9", $sformatf("vec %0d done seen", idx), int'(done), 1);
        check(freq, $sformatf("vec %0d flags", idx), int'(flags_out), int'(eflg));
        check("R8", $sformatf("vec %0d cycles", idx), int'(cycles), int'(ecyc));
        @(negedge clk);
        check("R9", $sformatf("vec %0d done width", idx), int'(done), 0);

        if (s == 3'd6)
            check("R1", $sformatf("vec %0d memory read", idx), int'(mr_cnt > mr0), 1);
        if (g == 2'd1) begin
            check("R7", $sformatf("vec %0d BIT reg writes", idx), rw_cnt - rw0, 0);
            check("R7", $sformatf("vec %0d BIT mem writes", idx), mw_cnt - mw0, 0);
        end else if (s == 3'd6) begin
            check("R7", $sformatf("vec %0d mem writes", idx), mw_cnt - mw0, 1);
            check("R7", $sformatf("vec %0d reg writes", idx), rw_cnt - rw0, 0);
            check("R7", $sformatf("vec %0d write addr", idx), int'(mw_adr), int'(HL_VAL));
            check(rreq, $sformatf("vec %0d mem result", idx), int'(mw_val), int'(eres));
        end else begin
            check("R7", $sformatf("vec %0d reg writes", idx), rw_cnt - rw0, 1);
            check("R7", $sformatf("vec %0d mem writes", idx), mw_cnt - mw0, 0);
            check("R1", $sformatf("vec %0d write index", idx), int'(rw_sel), int'(s));
            check(rreq, $sformatf("vec %0d reg result", idx), int'(rw_val), int'(eres));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 8; i++) regs[i] = 8'h10 + 8'(i);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9: quiet outputs under reset
        check("R9", "reset done", int'(done), 0);
        check("R9", "reset mem_rd", int'(mem_rd), 0);
        check("R9", "reset mem_wr", int'(mem_wr), 0);
        check("R9", "reset rf_we", int'(rf_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "idle done", int'(done), 0);

        for (int n = 0; n < NV; n++) run_vec(VECS[n], n);

        // R5 corner: same memory BIT, different memptr high byte flips Y/X
        run_vec({8'h46, 8'h00, 8'hFE, 8'h20, 8'hFE, 8'h74, 8'd12}, 100);
        // R2 corner: RR with carry in fills bit 7
        run_vec({8'h1B, 8'h01, 8'h00, 8'h00, 8'h80, 8'h80, 8'd8}, 101);
        // R4 corner: BIT 7 on clear bit leaves S low, keeps C
        run_vec({8'h78, 8'h01, 8'h7F, 8'h00, 8'h7F, 8'h7D, 8'd8}, 102);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule